// File: doc/BRIEF.md
# Table Block Move and Swap Engine

This engine relocates or exchanges a contiguous run of 68-bit entries that live in a search-table memory. A host hands it an 8-bit operation code and a 64-bit parameter word. The parameter word names two entry addresses, one device selector for each address, and a run length in entries. The engine checks the command in the cycle it arrives. A command that fails a check is refused at once and never reaches the memory.

A move reads the whole source run into an internal staging buffer with one burst. It then writes that buffer to the destination with a second burst. Because every read finishes before the first write, overlapping runs behave like a memmove. A swap reads the first run into one buffer and then the second run into another. It then writes the first run's data over the second run's addresses, and after that the second run's data over the first run's addresses.

The memory side is a single synchronous port. It carries an enable, a write strobe, a device selector and a 16-bit entry address. Read data comes back one cycle after the request. The engine reports `busy` while it works. When a command ends, whether it completed or was refused, the engine pulses `done` for one cycle and sets `err` to show the outcome.

Top module: `tbl_blkmove_engine`

## Requirements
- R1: The parameter word is decoded as follows: first/source address in bits 15:0, first/source device in bits 23:19, second/destination address in bits 39:24, second/destination device in bits 47:43, run length in bits 56:48. Bits 63:57, 42:40 and 18:16 have no effect on the operation.
- R2: Opcode 8'h04 selects a move and opcode 8'h05 selects a swap. Every other opcode is refused.
- R3: A length of zero, or a length above 128, is refused for both operations. A swap with a length below 4 is refused. Moves of 1 to 128 entries and swaps of 4 to 128 entries are accepted.
- R4: A command whose two device selectors differ is refused. A command in which either run's start address plus its length exceeds 65536 is refused. A run ending exactly at address 65535 is accepted.
- R5: When a command is refused, `mem_en` stays low and `busy` stays low. In the cycle after `cmd_valid` is sampled, `done` pulses with `err`=1.
- R6: A move issues `len` reads at consecutive cycles, starting the cycle after acceptance, to source addresses that rise by one per read. It then leaves one idle cycle. It then issues `len` consecutive writes to destination addresses that rise by one per write, each carrying the data read from the matching source entry.
- R7: A swap issues `len` reads of the first run and then `len` reads of the second run, followed by one idle cycle. It then writes the first run's data to the second run's addresses, and then the second run's data to the first run's addresses. All of these accesses are consecutive and the addresses rise by one per beat.
- R8: `busy` is high from the cycle after acceptance through the cycle of the last write. `done` is high for exactly the next cycle, with `err`=0. Out of reset, `busy`, `done`, `err` and `mem_en` are all low.
- R9: `cmd_valid` is ignored while `busy` is high.
- R10: Every memory access drives the command's device selector on `mem_dev`. The engine captures read data one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 8 | Operation code |
| cmd_param | input | 64 | Parameter word (addresses, devices, length) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Outcome of the last finished command (1 = refused) |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write strobe (0 = read) |
| mem_dev | output | 5 | Device selector |
| mem_addr | output | 16 | Entry address |
| mem_wdata | output | 68 | Write data |
| mem_rdata | input | 68 | Read data, valid one cycle after a read |

## Verification
Every move length from 1 to 128 and every swap length from 4 to 128 is run. Each written entry is compared with a shadow model of the memory. An off-by-one in the end-of-burst test would show up here as a missing or extra beat at length 1 or 128, or as a missing or extra beat at the swap minimum. Overlapping moves are run in both directions. A design that interleaved reads with writes would corrupt the trailing entries of those moves.

Each limit is probed on both sides: length 0, 129 and 511, a swap of length 3, runs that end exactly at the top of the address space or one entry past it, mismatched device selectors, and unknown opcodes. A design with a loose limit would touch memory for a command that should be refused.

A second command is pushed in while the engine is busy, and reserved parameter bits are set. Either mistake would show up as extra memory traffic or as wrong addresses.

// File: rtl/tbm_pkg.sv
// Shared constants and types for the table block move/swap engine.
// Assumes a fixed parameter-word layout; field offsets are fixed by the command format.
package tbm_pkg;
    localparam int ENTRY_W = 68;
    localparam int ADDR_W  = 16;
    localparam int DEV_W   = 5;
    localparam int LEN_W   = 9;
    localparam int OP_W    = 8;
    localparam int PARAM_W = 64;

    // Field offsets inside the parameter word
    localparam int FA_ADDR_LO = 0;
    localparam int FA_DEV_LO  = 19;
    localparam int FB_ADDR_LO = 24;
    localparam int FB_DEV_LO  = 43;
    localparam int FLEN_LO    = 48;

    localparam logic [OP_W-1:0] OP_MOVE = 8'h04;
    localparam logic [OP_W-1:0] OP_SWAP = 8'h05;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [ADDR_W-1:0] addr_a;
        logic [ADDR_W-1:0] addr_b;
        logic [LEN_W-1:0]  len;
        logic              is_swap;
    } job_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_A, ST_RD_B, ST_GAP, ST_WR_A, ST_WR_B
    } state_t;
endpackage

// File: rtl/tbm_decode.sv
// Command decoder and checker: splits the parameter word into a job and
// decides, in the same cycle, whether the command may run.
// Assumes runs must fit one device's address space and share one selector.
module tbm_decode
    import tbm_pkg::*;
#(
    parameter int MAX_LEN  = 128,
    parameter int MIN_SWAP = 4
) (
    input  logic [OP_W-1:0]    op,
    input  logic [PARAM_W-1:0] param,
    output job_t               job,
    output logic               ok
);
    localparam logic [ADDR_W:0] SPACE = {1'b1, {ADDR_W{1'b0}}};

    logic [DEV_W-1:0]  dev_a, dev_b;
    logic [ADDR_W:0]   end_a, end_b;
    logic              is_move, is_swap, len_ok;
    logic              unused_rsvd;

    // Field extraction
    assign dev_a      = param[FA_DEV_LO +: DEV_W];
    assign dev_b      = param[FB_DEV_LO +: DEV_W];
    assign job.addr_a = param[FA_ADDR_LO +: ADDR_W];
    assign job.addr_b = param[FB_ADDR_LO +: ADDR_W];
    assign job.len    = param[FLEN_LO +: LEN_W];
    assign job.dev    = dev_a;
    assign job.is_swap = is_swap;
    assign unused_rsvd = ^{param[63:57], param[42:40], param[18:16]};

    // Limit checks
    assign is_move = (op == OP_MOVE);
    assign is_swap = (op == OP_SWAP);
    assign end_a   = {1'b0, job.addr_a} + (ADDR_W+1)'(job.len);
    assign end_b   = {1'b0, job.addr_b} + (ADDR_W+1)'(job.len);
    assign len_ok  = (job.len != '0) && (job.len <= LEN_W'(MAX_LEN))
                   && (!is_swap || job.len >= LEN_W'(MIN_SWAP));
    assign ok = (is_move || is_swap) && len_ok && (dev_a == dev_b)
              && (end_a <= SPACE) && (end_b <= SPACE);
endmodule

// File: rtl/tbm_stage_buf.sv
// One staging buffer: synchronous write, combinational read.
// Assumes DEPTH covers the longest run; no reset on the storage.
module tbm_stage_buf #(
    parameter int DEPTH = 128,
    parameter int W     = 68,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] store [DEPTH];

    // Capture one entry per write strobe
    always_ff @(posedge clk) begin
        if (we) store[widx] <= wdata;
    end

    assign rdata = store[ridx];
endmodule

// File: rtl/tbm_sequencer.sv
// Burst sequencer: runs the read bursts, one turnaround cycle, then the write
// bursts, and reports busy/done/err. Assumes memory read latency of one cycle
// and an already-checked job.
module tbm_sequencer
    import tbm_pkg::*;
#(
    parameter int MAX_LEN = 128,
    localparam int IDX_W  = $clog2(MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              dec_ok,
    input  job_t              job_in,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mem_en,
    output logic              mem_we,
    output logic [DEV_W-1:0]  mem_dev,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        buf_we,
    output logic [IDX_W-1:0]  buf_widx,
    output logic [IDX_W-1:0]  buf_ridx,
    output logic              buf_rsel
);
    state_t            state;
    job_t              job_q;
    logic [IDX_W-1:0]  cnt;
    logic              last, issue_rd, issue_wr;
    logic              rd_pend, rd_sel;
    logic [IDX_W-1:0]  rd_idx;
    logic [ADDR_W-1:0] base;

    assign last     = (LEN_W'(cnt) + LEN_W'(1)) == job_q.len;
    assign issue_rd = (state == ST_RD_A) || (state == ST_RD_B);
    assign issue_wr = (state == ST_WR_A) || (state == ST_WR_B);

    // Control state, beat counter and completion status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            job_q <= '0;
            cnt   <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (cmd_valid) begin
                    if (dec_ok) begin
                        job_q <= job_in;
                        cnt   <= '0;
                        state <= ST_RD_A;
                    end else begin
                        done <= 1'b1;
                        err  <= 1'b1;
                    end
                end
                ST_RD_A: if (last) begin
                    cnt   <= '0;
                    state <= job_q.is_swap ? ST_RD_B : ST_GAP;
                end else cnt <= cnt + 1'b1;
                ST_RD_B: if (last) begin
                    cnt   <= '0;
                    state <= ST_GAP;
                end else cnt <= cnt + 1'b1;
                ST_GAP: state <= ST_WR_A;
                ST_WR_A: if (last) begin
                    cnt <= '0;
                    if (job_q.is_swap) state <= ST_WR_B;
                    else begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        err   <= 1'b0;
                    end
                end else cnt <= cnt + 1'b1;
                ST_WR_B: if (last) begin
                    cnt   <= '0;
                    state <= ST_IDLE;
                    done  <= 1'b1;
                    err   <= 1'b0;
                end else cnt <= cnt + 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Read-return pipeline: where the data arriving next cycle belongs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            rd_sel  <= 1'b0;
            rd_idx  <= '0;
        end else begin
            rd_pend <= issue_rd;
            rd_sel  <= (state == ST_RD_B);
            rd_idx  <= cnt;
        end
    end

    // Memory port and buffer steering
    always_comb begin
        base = ((state == ST_RD_A) || (state == ST_WR_B)) ? job_q.addr_a : job_q.addr_b;
        mem_addr = base + ADDR_W'(cnt);
    end

    assign busy     = (state != ST_IDLE);
    assign mem_en   = issue_rd || issue_wr;
    assign mem_we   = issue_wr;
    assign mem_dev  = job_q.dev;
    assign buf_we   = {rd_pend & rd_sel, rd_pend & ~rd_sel};
    assign buf_widx = rd_idx;
    assign buf_ridx = cnt;
    assign buf_rsel = (state == ST_WR_B);
endmodule

// File: rtl/tbl_blkmove_engine.sv
// Top of the table block move/swap engine: decoder, two staging buffers and
// the burst sequencer. Assumes a one-cycle-latency synchronous memory port.
module tbl_blkmove_engine
    import tbm_pkg::*;
#(
    parameter int MAX_LEN  = 128,
    parameter int MIN_SWAP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [OP_W-1:0]    cmd_op,
    input  logic [PARAM_W-1:0] cmd_param,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               mem_en,
    output logic               mem_we,
    output logic [DEV_W-1:0]   mem_dev,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ENTRY_W-1:0] mem_wdata,
    input  logic [ENTRY_W-1:0] mem_rdata
);
    localparam int IDX_W = $clog2(MAX_LEN);

    job_t               job;
    logic               dec_ok;
    logic [1:0]         buf_we;
    logic [IDX_W-1:0]   buf_widx, buf_ridx;
    logic               buf_rsel;
    logic [ENTRY_W-1:0] buf_rd [2];

    tbm_decode #(.MAX_LEN(MAX_LEN), .MIN_SWAP(MIN_SWAP)) u_dec (
        .op(cmd_op), .param(cmd_param), .job(job), .ok(dec_ok)
    );

    for (genvar g = 0; g < 2; g++) begin : g_buf
        tbm_stage_buf #(.DEPTH(MAX_LEN), .W(ENTRY_W)) u_buf (
            .clk(clk), .we(buf_we[g]), .widx(buf_widx), .wdata(mem_rdata),
            .ridx(buf_ridx), .rdata(buf_rd[g])
        );
    end

    tbm_sequencer #(.MAX_LEN(MAX_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .dec_ok(dec_ok),
        .job_in(job), .busy(busy), .done(done), .err(err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_dev(mem_dev), .mem_addr(mem_addr),
        .buf_we(buf_we), .buf_widx(buf_widx), .buf_ridx(buf_ridx), .buf_rsel(buf_rsel)
    );

    assign mem_wdata = buf_rsel ? buf_rd[1] : buf_rd[0];
endmodule

// File: rtl/tbm_checker.sv
// Protocol checker for the move/swap engine, attached by bind.
// Assumes synchronous active-low reset held for at least one clock.
module tbm_checker
    import tbm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             mem_en,
    input logic             mem_we,
    input logic [DEV_W-1:0] mem_dev
);
    // R5
    no_idle_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    // R8
    done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_en && !mem_we));

    // R8
    finish_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && !err));

    // R5
    err_only_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(err));

    // R10
    dev_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_dev));
endmodule

bind tbl_blkmove_engine tbm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_dev(mem_dev)
);

// File: tb/tb_tbl_blkmove_engine.sv
`timescale 1ns/100ps
// Self-checking bench: sweeps move and swap lengths, probes every limit, and
// compares the memory against a shadow model updated from the requirements.
module tb_tbl_blkmove_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic [63:0] cmd_param = '0;
    logic        busy, done, err, mem_en, mem_we;
    logic [4:0]  mem_dev;
    logic [15:0] mem_addr;
    logic [67:0] mem_wdata;
    logic [67:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [67:0] mem_q [int];
    logic [67:0] sh_q  [int];

    always #2.5 clk = ~clk;

    tbl_blkmove_engine dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_param(cmd_param), .busy(busy), .done(done), .err(err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_dev(mem_dev), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic int key_of(int dev, int addr);
        return ((dev & 31) << 16) | (addr & 16'hFFFF);
    endfunction

    function automatic logic [67:0] init_val(int k);
        logic [31:0] h = 32'(k) * 32'h9E3779B1;
        return {4'(k), h, 11'h5A5, 21'(k)};
    endfunction

    function automatic logic [67:0] mem_get(int k);
        return mem_q.exists(k) ? mem_q[k] : init_val(k);
    endfunction

    function automatic logic [67:0] sh_get(int k);
        return sh_q.exists(k) ? sh_q[k] : init_val(k);
    endfunction

    // Memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_q[key_of(int'(mem_dev), int'(mem_addr))] = mem_wdata;
            else mem_rdata <= mem_get(key_of(int'(mem_dev), int'(mem_addr)));
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(int a, int da, int b, int db, int len);
        logic [63:0] p = '0;
        p[15:0]  = 16'(a);
        p[23:19] = 5'(da);
        p[39:24] = 16'(b);
        p[47:43] = 5'(db);
        p[56:48] = 9'(len);
        return p;
    endfunction

    // Issue one command, watch the port, and check against the requirements
    task automatic run_cmd(input logic [7:0] op, input logic [63:0] p,
                           input bit exp_ok, input bit poke, input string req);
        int a = int'(p[15:0]);
        int b = int'(p[39:24]);
        int dev = int'(p[23:19]);
        int len = int'(p[56:48]);
        bit swp = (op == 8'h05);
        int nbeat = exp_ok ? (swp ? 2 * len : len) : 0;
        int rd_a[256], rd_c[256], wr_a[256], wr_c[256];
        logic [67:0] wr_d[256];
        logic [67:0] old_a[128], old_b[128];
        int nr = 0, nw = 0, nbusy = 0, done_at = 0, devbad = 0;
        int bad_seq = 0, bad_dat = 0, bad_mem = 0;
        if (exp_ok) begin
            for (int k = 0; k < len; k++) begin
                old_a[k] = sh_get(key_of(dev, a + k));
                old_b[k] = sh_get(key_of(dev, b + k));
            end
        end
        @(negedge clk);
        cmd_op = op; cmd_param = p; cmd_valid = 1'b1;
        for (int i = 1; i <= 1200; i++) begin
            @(negedge clk);
            cmd_valid = poke && (i == 3);
            if (busy) nbusy++;
            if (mem_en) begin
                if (int'(mem_dev) != dev) devbad++;
                if (!mem_we && nr < 256) begin rd_a[nr] = int'(mem_addr); rd_c[nr] = i; nr++; end
                if (mem_we && nw < 256) begin
                    wr_a[nw] = int'(mem_addr); wr_c[nw] = i; wr_d[nw] = mem_wdata; nw++;
                end
            end
            if (done) begin done_at = i; break; end
        end
        cmd_valid = 1'b0;
        check(done_at == (exp_ok ? 2 * nbeat + 2 : 1), req, "done cycle", 68'(done_at),
              68'(exp_ok ? 2 * nbeat + 2 : 1));
        check(err == !exp_ok, req, "err", 68'(err), 68'(!exp_ok));
        check(nbusy == (exp_ok ? 2 * nbeat + 1 : 0), "R8", "busy cycles", 68'(nbusy),
              68'(exp_ok ? 2 * nbeat + 1 : 0));
        check(nr == nbeat && nw == nbeat, exp_ok ? req : "R5", "beat count",
              68'(nr * 1000 + nw), 68'(nbeat * 1000 + nbeat));
        check(devbad == 0, "R10", "device selector", 68'(devbad), 68'(0));
        @(negedge clk);
        check(!done, "R8", "done width", 68'(done), 68'(0));
        if (exp_ok && nr == nbeat && nw == nbeat) begin
            for (int k = 0; k < nbeat; k++) begin
                int ea = (k < len) ? a + k : b + (k - len);
                int ew = (k < len) ? b + k : a + (k - len);
                logic [67:0] ed = (k < len) ? old_a[k] : old_b[k - len];
                if (rd_a[k] != ea || rd_c[k] != k + 1) bad_seq++;
                if (wr_a[k] != ew || wr_c[k] != nbeat + 2 + k) bad_seq++;
                if (wr_d[k] !== ed) bad_dat++;
            end
            check(bad_seq == 0, req, "address/cycle order", 68'(bad_seq), 68'(0));
            check(bad_dat == 0, req, "write data", 68'(bad_dat), 68'(0));
            for (int k = 0; k < len; k++) sh_q[key_of(dev, b + k)] = old_a[k];
            if (swp) for (int k = 0; k < len; k++) sh_q[key_of(dev, a + k)] = old_b[k];
            for (int k = 0; k < len; k++) begin
                if (mem_get(key_of(dev, a + k)) !== sh_get(key_of(dev, a + k))) bad_mem++;
                if (mem_get(key_of(dev, b + k)) !== sh_get(key_of(dev, b + k))) bad_mem++;
            end
            check(bad_mem == 0, req, "memory contents", 68'(bad_mem), 68'(0));
        end
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(!busy && !done && !err && !mem_en, "R8", "reset state",
              68'({busy, done, err, mem_en}), 68'(0));
        // R1: reserved bits set
        run_cmd(8'h04, mk(100, 3, 400, 3, 20) | 64'hFE00_0700_0007_0000, 1'b1, 1'b0, "R1");
        // R6: every move length
        for (int len = 1; len <= 128; len++)
            run_cmd(8'h04, mk((len * 517) & 16'h3FFF, len % 32, ((len * 517) & 16'h3FFF) + 300,
                    len % 32, len), 1'b1, 1'b0, "R6");
        // R6: overlapping moves in both directions
        run_cmd(8'h04, mk(1000, 7, 1010, 7, 50), 1'b1, 1'b0, "R6");
        run_cmd(8'h04, mk(2010, 7, 2000, 7, 50), 1'b1, 1'b0, "R6");
        // R7: every swap length
        for (int len = 4; len <= 128; len++)
            run_cmd(8'h05, mk(len * 37, (len + 5) % 32, len * 37 + 200, (len + 5) % 32, len),
                    1'b1, 1'b0, "R7");
        // R9: second command while busy
        run_cmd(8'h04, mk(5000, 9, 6000, 9, 16), 1'b1, 1'b1, "R9");
        // R4: boundaries
        run_cmd(8'h04, mk(16'hFF80, 2, 300, 2, 128), 1'b1, 1'b0, "R4");
        run_cmd(8'h05, mk(16, 2, 16'hFFF0, 2, 16), 1'b1, 1'b0, "R4");
        run_cmd(8'h04, mk(16'hFF81, 2, 300, 2, 128), 1'b0, 1'b0, "R4");
        run_cmd(8'h04, mk(300, 2, 16'hFFF1, 2, 16), 1'b0, 1'b0, "R4");
        run_cmd(8'h04, mk(10, 1, 500, 2, 8), 1'b0, 1'b0, "R4");
        // R3: length limits
        run_cmd(8'h04, mk(10, 1, 500, 1, 0), 1'b0, 1'b0, "R3");
        run_cmd(8'h04, mk(10, 1, 500, 1, 129), 1'b0, 1'b0, "R3");
        run_cmd(8'h05, mk(10, 1, 500, 1, 511), 1'b0, 1'b0, "R3");
        run_cmd(8'h05, mk(10, 1, 500, 1, 3), 1'b0, 1'b0, "R3");
        // R2: unknown opcodes
        run_cmd(8'h00, mk(10, 1, 500, 1, 8), 1'b0, 1'b0, "R2");
        run_cmd(8'h06, mk(10, 1, 500, 1, 8), 1'b0, 1'b0, "R2");
        run_cmd(8'hFF, mk(10, 1, 500, 1, 8), 1'b0, 1'b0, "R2");
        // R5: a good command after refusals clears err
        run_cmd(8'h05, mk(30, 4, 90, 4, 4), 1'b1, 1'b0, "R5");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule